// File: doc/BRIEF.md
# Last-Target Indirect Branch Predictor

This block guesses where an indirect jump or call will go by recalling the destination that was last seen for its table slot. The slot is picked by the low address bits of the branch instruction, and there is no tag, so two branches whose addresses agree in those bits share a slot and can overwrite each other. A front end presents a branch address on the lookup port and receives the stored destination in the same cycle. When the branch resolves, the back end presents the branch address and the real destination on the update port.

On an update, the block compares the stored destination with the real one and flags a miss if they differ. It writes the real destination into the slot at the same clock edge, so the next branch that maps there is predicted to go to it. Two saturating event counters record how many indirect branches were resolved and how many of them were predicted wrongly. Reset clears the whole table to zero, which means the first branch into any slot misses unless its real destination is address zero.

Top module: `itp_last_target`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears every table slot to zero, both counters to zero and `up_mispredict` to 0. After reset, a lookup at any address returns zero until that slot is written.
- R2: The slot index is bits [8:0] of the branch address (512 slots by default). Addresses that differ only above bit 8 use the same slot.
- R3: `lk_target` is a combinational read of the slot selected by `lk_addr`. It gives the destination most recently written into that slot.
- R4: `up_mispredict` is 1 for exactly the one cycle after an edge where `up_valid` was 1 and the stored destination differed from `up_target`. It is 0 in every other cycle.
- R5: At an edge where `up_valid` is 1, `up_target` is written into the slot selected by `up_addr`.
- R6: When a lookup and an update address the same slot in the same cycle, `lk_target` returns the value stored before the update.
- R7: `exec_count` increases by one at every edge where `up_valid` is 1.
- R8: `miss_count` increases by one at every edge where an update mispredicts, so it never exceeds `exec_count`.
- R9: Both counters stop at all ones and do not wrap.
- R10: When `up_valid` is 0, `up_addr` and `up_target` are ignored: the table and both counters keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_addr | input | ADDR_W | Address of the branch being predicted |
| lk_target | output | ADDR_W | Predicted destination for `lk_addr` |
| up_valid | input | 1 | A resolved indirect branch is presented this cycle |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_target | input | ADDR_W | Real destination of the resolved branch |
| up_mispredict | output | 1 | One-cycle pulse after an update whose prediction was wrong |
| exec_count | output | CNT_W | Saturating count of resolved indirect branches |
| miss_count | output | CNT_W | Saturating count of mispredicted indirect branches |

## Verification
The assertions assume that `up_valid` is a clean 0 or 1 at every edge after reset. They also assume that the update address is still driven in the cycle after a write, so the write-through check can match slot indices. The bench drives all inputs at the falling edge and keeps them steady through the next rising edge. It uses a narrow address range and a short list of destinations, so hits, misses, aliasing and same-slot collisions all occur often. It builds the counters with a small width so that saturation happens within the run.

// File: rtl/itp_pkg.sv
// Package: shared defaults for the last-target indirect branch predictor.
// Assumes: users override the widths per instance where needed.
package itp_pkg;
    localparam int ITP_ADDR_W_DEF = 32;  // branch address and target width
    localparam int ITP_IDX_W_DEF  = 9;   // slot index width (512 slots)
    localparam int ITP_CNT_W_DEF  = 32;  // event counter width
    localparam int ITP_NUM_EVT    = 2;   // number of event counters

    // Event counter slots
    typedef enum logic [0:0] {
        EVT_EXEC = 1'b0,
        EVT_MISS = 1'b1
    } itp_evt_e;
endpackage

// File: rtl/itp_target_table.sv
// Module: direct-mapped, untagged target storage with two combinational
// read ports and one write port.
// Assumes: a write takes effect at the clock edge, so a read in the
// same cycle sees the old contents. Synchronous active-low reset clears
// every slot.
module itp_target_table #(
    parameter int IDX_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd0_idx,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [IDX_W-1:0]  rd1_idx,
    output logic [DATA_W-1:0] rd1_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] slots [DEPTH];

    // Clear all slots on reset, otherwise store one target per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else if (wr_en) begin
            slots[wr_idx] <= wr_data;
        end
    end

    // Read both ports from the stored contents (read-before-write).
    always_comb begin
        rd0_data = slots[rd0_idx];
        rd1_data = slots[rd1_idx];
    end

    // A written target is visible on the compare port one edge later.
    AST_TBL_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && (rd1_idx == $past(wr_idx)))
            |-> (rd1_data == $past(wr_data)))
        else $error("table write not visible"); // R5
endmodule

// File: rtl/itp_miss_detect.sv
// Module: compares the stored target with the resolved target and
// registers a one-cycle mispredict pulse.
// Assumes: the stored value is the pre-write contents of the slot.
module itp_miss_detect #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [DATA_W-1:0] stored,
    input  logic [DATA_W-1:0] actual,
    output logic              miss_now,
    output logic              miss_q
);
    // Flag a mismatch on a valid update.
    always_comb begin
        miss_now = valid && (stored != actual);
    end

    // Register the mismatch as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_q <= 1'b0;
        end else begin
            miss_q <= miss_now;
        end
    end

    // Without an update there is no pulse in the next cycle.
    AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> !miss_q)
        else $error("pulse without update"); // R4
    // A matching update produces no pulse.
    AST_PULSE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (stored == actual)) |=> !miss_q)
        else $error("pulse on correct prediction"); // R4
endmodule

// File: rtl/itp_sat_counter.sv
// Module: event counter that stops at all ones.
// Assumes: inc is a single-cycle event strobe.
module itp_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count events until the maximum is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

    // Once full, the counter stays full.
    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX) |=> (count == CNT_MAX))
        else $error("counter wrapped"); // R9
    // Below full, an event adds exactly one.
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (count != CNT_MAX)) |=> (count == $past(count) + 1'b1))
        else $error("counter step wrong"); // R7
    // No event, no change.
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count))
        else $error("counter moved without event"); // R10
endmodule

// File: rtl/itp_last_target.sv
// Module: top of the last-target indirect branch predictor. Lookup is
// combinational. An update compares, pulses on a mismatch, overwrites
// the slot and bumps the event counters, all at one clock edge.
// Assumes: ADDR_W >= IDX_W; synchronous active-low reset.
module itp_last_target
    import itp_pkg::*;
#(
    parameter int ADDR_W = ITP_ADDR_W_DEF,
    parameter int IDX_W  = ITP_IDX_W_DEF,
    parameter int CNT_W  = ITP_CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [ADDR_W-1:0] lk_target,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [ADDR_W-1:0] up_target,
    output logic              up_mispredict,
    output logic [CNT_W-1:0]  exec_count,
    output logic [CNT_W-1:0]  miss_count
);
    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  up_idx;
    logic [ADDR_W-1:0] up_stored;
    logic              miss_now;
    logic [ITP_NUM_EVT-1:0] evt_inc;
    logic [CNT_W-1:0]  evt_cnt [ITP_NUM_EVT];

    // Slot selection from the low address bits.
    always_comb begin
        lk_idx = lk_addr[IDX_W-1:0];
        up_idx = up_addr[IDX_W-1:0];
    end

    itp_target_table #(
        .IDX_W  (IDX_W),
        .DATA_W (ADDR_W)
    ) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_data  (up_target),
        .rd0_idx  (lk_idx),
        .rd0_data (lk_target),
        .rd1_idx  (up_idx),
        .rd1_data (up_stored)
    );

    itp_miss_detect #(
        .DATA_W (ADDR_W)
    ) miss_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (up_valid),
        .stored   (up_stored),
        .actual   (up_target),
        .miss_now (miss_now),
        .miss_q   (up_mispredict)
    );

    // Route event strobes to the counters.
    always_comb begin
        evt_inc[EVT_EXEC] = up_valid;
        evt_inc[EVT_MISS] = miss_now;
    end

    for (genvar g = 0; g < ITP_NUM_EVT; g++) begin : g_evt
        itp_sat_counter #(
            .CNT_W (CNT_W)
        ) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (evt_inc[g]),
            .count (evt_cnt[g])
        );
    end

    assign exec_count = evt_cnt[EVT_EXEC];
    assign miss_count = evt_cnt[EVT_MISS];

    // Reset leaves counters at zero and no pulse.
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> ((exec_count == '0) && (miss_count == '0) && !up_mispredict))
        else $error("reset state wrong"); // R1
    // Mispredicts never outnumber resolved branches.
    AST_MISS_LE_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        miss_count <= exec_count)
        else $error("miss count above exec count"); // R8
    // A pulse always comes from a counted update.
    AST_PULSE_HAS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        up_mispredict |-> $past(up_valid))
        else $error("pulse without prior update"); // R4
endmodule

// File: tb/itp_last_target_tb_top.sv
// Bench: behavioural reference model compared every cycle.
module itp_last_target_tb_top;
    localparam int AW  = 32;
    localparam int IW  = 9;
    localparam int CW  = 6;
    localparam int NSL = 1 << IW;
    localparam longint CMAX = (64'd1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic [AW-1:0] lk_target;
    logic          up_valid = 1'b0;
    logic [AW-1:0] up_addr = '0;
    logic [AW-1:0] up_target = '0;
    logic          up_mispredict;
    logic [CW-1:0] exec_count;
    logic [CW-1:0] miss_count;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // Reference state
    logic [AW-1:0] m_tbl [NSL];
    longint m_exec = 0;
    longint m_miss = 0;
    bit     m_pulse = 0;

    always #4 clk = ~clk;   // 125 MHz

    itp_last_target #(.ADDR_W(AW), .IDX_W(IW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_target(lk_target),
        .up_valid(up_valid), .up_addr(up_addr), .up_target(up_target),
        .up_mispredict(up_mispredict), .exec_count(exec_count),
        .miss_count(miss_count)
    );

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, check lookup, clock, check registered outputs.
    task automatic step(input bit uv, input logic [AW-1:0] ua, input logic [AW-1:0] ut,
                        input logic [AW-1:0] la, input string lreq);
        int ui;
        up_valid = uv; up_addr = ua; up_target = ut; lk_addr = la;
        #1;
        check(lreq, lk_target, m_tbl[la % NSL]);
        ui = int'(ua % NSL);
        m_pulse = uv && (m_tbl[ui] != ut);
        if (uv) begin
            m_tbl[ui] = ut;
            if (m_exec < CMAX) m_exec++;
        end
        if (m_pulse && m_miss < CMAX) m_miss++;
        @(posedge clk);
        @(negedge clk);
        check("R4 mispredict pulse", up_mispredict, m_pulse);
        check("R7/R9 exec count", exec_count, m_exec);
        check("R8/R9 miss count", miss_count, m_miss);
    endtask

    function automatic logic [AW-1:0] pick_tgt();
        case ($urandom % 4)
            0: return 32'h0000_0000;
            1: return 32'h0040_1000;
            2: return 32'h0040_2000;
            default: return 32'h8000_0040;
        endcase
    endfunction

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        for (int i = 0; i < NSL; i++) m_tbl[i] = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 exec after reset", exec_count, 0);
        check("R1 miss after reset", miss_count, 0);
        check("R1 pulse after reset", up_mispredict, 0);
        for (int a = 0; a < 4; a++) begin
            lk_addr = 32'h1234_0000 + a * 97; #1;
            check("R1 lookup after reset", lk_target, 0);
        end
        @(negedge clk);
        // R1: first use with zero target hits
        step(1, 32'h0000_0010, 32'h0, 32'h0000_0010, "R1 zero slot");
        // R5/R3: write then read
        step(1, 32'h0000_0104, 32'hCAFE_0000, 32'h0, "R3 lookup");
        step(0, 32'h0, 32'h0, 32'h0000_0104, "R3 lookup after write");
        // R2: alias above bit 8
        step(0, 32'h0, 32'h0, 32'hABCD_E104, "R2 alias lookup");
        step(1, 32'hFFFF_FF04, 32'hCAFE_0000, 32'h0000_0104, "R2 alias update hit");
        // R6: same-slot lookup and update in one cycle
        step(1, 32'h0000_0104, 32'hBEEF_0000, 32'h0000_0104, "R6 read-before-write");
        step(0, 32'h0, 32'h0, 32'h0000_0104, "R5 new value stored");
        // R10: ignored update
        step(0, 32'h0000_0104, 32'h1111_1111, 32'h0000_0104, "R10 idle update");
        step(0, 32'h0, 32'h0, 32'h0000_0104, "R10 slot unchanged");
        // Random traffic, narrow range; reaches counter saturation (R9)
        for (int k = 0; k < 600; k++) begin
            logic [AW-1:0] a1, a2;
            a1 = ($urandom % 8) * 32'h200 + ($urandom % 6);
            a2 = ($urandom % 8) * 32'h200 + ($urandom % 6);
            step(($urandom % 5) != 0, a1, pick_tgt(), (k % 3 == 0) ? a1 : a2, "R3/R6 random lookup");
        end
        check("R9 exec saturated", exec_count, CMAX);
        step(1, 32'h0000_0001, 32'h7777_0000, 32'h0000_0001, "R9 lookup");
        check("R9 exec held at max", exec_count, CMAX);
        finish_run();
    end
endmodule